// File: doc/BRIEF.md
# Soft-Switching Bridge Gate Sequencer

This block produces the gate commands for a four-switch full-bridge boost stage with an isolation transformer, plus the single auxiliary switch that creates a zero-voltage window before the bridge turns back on. A free-running period counter sets a constant switching frequency. At a fixed count in each period, set by the duty word, one diagonal pair of the bridge is released while the other pair keeps conducting. Each period releases the other pair, so the transformer core never walks toward saturation. Later in the period the auxiliary switch is fired. Once the digital "resonant capacitor at zero" flag arrives and a programmable hold has elapsed, the released pair is driven on again. The auxiliary switch is dropped only after that.

The duty word, period length and auxiliary lead are captured together at each period start. A change made in the middle of a period therefore never takes effect partway through it. If the zero flag does not arrive in time, a timeout forces the pair back on and sets a sticky fault output. A phase code shows which step of the sequence is active.

Top module: `zvs_bridge_seq`

## Requirements
- R1: While the synchronous reset is high, all four bridge gates and the auxiliary gate are off, phase reads 0 and fault reads 0. The first turn-off after reset releases pair 0, which is sw_on[0] and sw_on[3]. Pair 1 is sw_on[1] and sw_on[2].
- R2: In the on-interval (phase 1), all four bridge gates are on and the auxiliary gate is off. This interval runs from re-enable until the period count equals the latched duty word.
- R3: At turn-off (phase 2), exactly one diagonal pair is off and the other pair stays on. sw_on reads 4'b0110 when pair 0 is released and 4'b1001 when pair 1 is released. The auxiliary gate is off.
- R4: The released pair alternates on every successive turn-off.
- R5: When the period count reaches period minus lead, the auxiliary gate turns on (phase 3) while the released pair is still off.
- R6: In phase 3 the released pair stays off until zero_det is sampled high. After that sample the block moves to the hold step.
- R7: The hold step (phase 4) lasts max(hold_cmd,1) cycles with the pair still off. The pair is then re-enabled.
- R8: In the re-enable cycle (phase 5), all four bridge gates are on and the auxiliary gate is still on. The auxiliary gate drops on the following cycle.
- R9: Successive turn-offs are exactly period_cmd cycles apart while the commands are constant.
- R10: duty_cmd, period_cmd and lead_cmd are captured only at the period start. A change made mid-period first affects the following period.
- R11: If zero_det does not arrive within max(tmo_cmd,1) cycles of phase 3, the pair is forced back on (phase 5). fault then rises and stays high until reset.
- R12: A duty word of at least the period length keeps all four bridge gates on for the whole period, with no turn-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_cmd | input | CW | Turn-off count within the period |
| period_cmd | input | CW | Switching period in cycles |
| lead_cmd | input | CW | Cycles before period end at which the auxiliary gate fires |
| hold_cmd | input | CW | Zero-voltage hold length in cycles |
| tmo_cmd | input | CW | Maximum wait for the zero flag in cycles |
| zero_det | input | 1 | Resonant capacitor voltage has reached zero |
| sw_on | output | 4 | Bridge gate enables; pair 0 is bits 0 and 3, pair 1 is bits 1 and 2 |
| aux_on | output | 1 | Auxiliary gate enable |
| phase | output | 3 | 0 off, 1 on, 2 clamp, 3 aux, 4 hold, 5 re-enable |
| fault | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with an 8-bit count width and a 40-cycle period. A full period, with its turn-off, auxiliary firing, hold and re-enable, then spans only a few dozen cycles, so many periods fit in one run. With the narrow width, a duty word above the period length is still representable, and a timeout of 6 cycles and hold lengths of 0, 2 and 5 all fit inside one period. This allows the exact spacing of turn-offs and the one-period delay of a duty change to be measured directly.

// File: rtl/zvs_bridge_seq.sv
module zvs_bridge_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] duty_cmd,
  input  logic [CW-1:0] period_cmd,
  input  logic [CW-1:0] lead_cmd,
  input  logic [CW-1:0] hold_cmd,
  input  logic [CW-1:0] tmo_cmd,
  input  logic          zero_det,
  output logic [3:0]    sw_on,
  output logic          aux_on,
  output logic [2:0]    phase,
  output logic          fault
);

  typedef enum logic [2:0] {
    PH_OFF = 3'd0, PH_ON = 3'd1, PH_CLAMP = 3'd2,
    PH_AUX = 3'd3, PH_HOLD = 3'd4, PH_REON = 3'd5
  } ph_t;

  ph_t           st;
  logic [CW-1:0] cnt, duty_q, per_q, lead_q, tmr, aux_at;
  logic [CW:0]   tmr_inc;
  logic          sel, wrap, hold_done, tmo_done;
  logic [3:0]    pair_left;

  assign wrap      = (per_q <= CW'(1)) || (cnt >= per_q - CW'(1));
  assign aux_at    = (lead_q >= per_q) ? '0 : per_q - lead_q;
  assign tmr_inc   = {1'b0, tmr} + {{CW{1'b0}}, 1'b1};
  assign hold_done = tmr_inc >= {1'b0, hold_cmd};
  assign tmo_done  = tmr_inc >= {1'b0, tmo_cmd};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PH_OFF;
      cnt    <= '0;
      duty_q <= duty_cmd;
      per_q  <= period_cmd;
      lead_q <= lead_cmd;
      tmr    <= '0;
      sel    <= 1'b0;
      fault  <= 1'b0;
    end else begin
      if (wrap) begin
        cnt    <= '0;
        duty_q <= duty_cmd;
        per_q  <= period_cmd;
        lead_q <= lead_cmd;
      end else begin
        cnt <= cnt + CW'(1);
      end
      case (st)
        PH_OFF:   st <= PH_ON;
        PH_ON:    if (cnt == duty_q) st <= PH_CLAMP;
        PH_CLAMP: if (cnt >= aux_at) begin
                    st  <= PH_AUX;
                    tmr <= '0;
                  end
        PH_AUX:   if (zero_det) begin
                    st  <= PH_HOLD;
                    tmr <= '0;
                  end else if (tmo_done) begin
                    st    <= PH_REON;
                    fault <= 1'b1;
                  end else begin
                    tmr <= tmr + CW'(1);
                  end
        PH_HOLD:  if (hold_done) st <= PH_REON;
                  else tmr <= tmr + CW'(1);
        PH_REON:  begin
                    st  <= PH_ON;
                    sel <= ~sel;
                  end
        default:  st <= PH_OFF;
      endcase
    end
  end

  assign pair_left = sel ? 4'b1001 : 4'b0110;
  assign sw_on  = (st == PH_ON || st == PH_REON) ? 4'hF :
                  (st inside {PH_CLAMP, PH_AUX, PH_HOLD}) ? pair_left : 4'h0;
  assign aux_on = st inside {PH_AUX, PH_HOLD, PH_REON};
  assign phase  = st;

  // R3
  split_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_CLAMP && $past(st) == PH_ON) |->
      ($countones(sw_on) == 2 && (sw_on == 4'b0110 || sw_on == 4'b1001)));

  // R5
  aux_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_on == 4'hF && $past(sw_on) != 4'hF && $past(sw_on) != 4'h0) |-> $past(aux_on));

  // R8
  aux_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(aux_on) |-> ($past(sw_on) == 4'hF && sw_on == 4'hF));

  // R6
  zero_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HOLD && $past(st) == PH_AUX) |-> $past(zero_det));

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fault) |-> fault);

  // R10
  duty_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt != '0) |-> $stable(duty_q));

endmodule

// File: tb/zvs_bridge_seq_tb.sv
`timescale 1ns/1ps
module zvs_bridge_seq_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] duty_cmd = 8'd10, period_cmd = 8'd40, lead_cmd = 8'd8;
  logic [CW-1:0] hold_cmd = 8'd2, tmo_cmd = 8'd20;
  logic          zero_det = 1'b0;
  logic [3:0]    sw_on;
  logic          aux_on, fault;
  logic [2:0]    phase;

  int errs = 0, nchk = 0, cyc = 0;
  bit resp_en = 1'b0;
  int zdly = 3;

  zvs_bridge_seq #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .duty_cmd(duty_cmd), .period_cmd(period_cmd),
    .lead_cmd(lead_cmd), .hold_cmd(hold_cmd), .tmo_cmd(tmo_cmd),
    .zero_det(zero_det), .sw_on(sw_on), .aux_on(aux_on), .phase(phase),
    .fault(fault));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin : responder
    int zc;
    zc = 0;
    forever begin
      @(negedge clk);
      if (resp_en && phase == 3'd3) begin
        zc++;
        zero_det = (zc >= zdly);
      end else begin
        zc = 0;
        zero_det = 1'b0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(int p);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (phase == p[2:0]) return;
    end
    check("wait_phase", int'(phase), p);
  endtask

  task automatic wait_turnoff(output int t);
    logic [2:0] prev;
    prev = phase;
    t = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (phase == 3'd2 && prev != 3'd2) begin
        t = cyc;
        return;
      end
      prev = phase;
    end
    check("wait_turnoff", 0, 1);
  endtask

  task automatic count_phase(int p, output int n, input bit chk_off);
    n = 0;
    while (phase == p[2:0] && n < 300) begin
      if (chk_off) check("R6 pair held off", int'(sw_on == 4'hF), 0);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 gates", int'(sw_on), 0);
    check("R1 aux", int'(aux_on), 0);
    check("R1 phase", int'(phase), 0);
    check("R1 fault", int'(fault), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 on phase", int'(phase), 1);
    check("R2 all on", int'(sw_on), 15);
    check("R2 aux off", int'(aux_on), 0);
  endtask

  task automatic t_first_seq;
    int n;
    resp_en = 1'b1;
    wait_phase(2);
    check("R1 first pair", int'(sw_on), 4'b0110);
    check("R3 aux off", int'(aux_on), 0);
    wait_phase(3);
    check("R5 aux on", int'(aux_on), 1);
    check("R5 pair off", int'(sw_on), 4'b0110);
    count_phase(3, n, 1'b1);
    check("R6 aux length", n, 3);
    count_phase(4, n, 1'b1);
    check("R7 hold 2", n, 2);
    check("R8 reon phase", int'(phase), 5);
    check("R8 reon gates", int'(sw_on), 15);
    check("R8 reon aux", int'(aux_on), 1);
    @(negedge clk);
    check("R8 aux dropped", int'(aux_on), 0);
    check("R2 back on", int'(sw_on), 15);
  endtask

  task automatic t_alternate;
    int t1, t2;
    wait_turnoff(t1);
    check("R4 second pair", int'(sw_on), 4'b1001);
    wait_turnoff(t2);
    check("R4 third pair", int'(sw_on), 4'b0110);
    check("R9 spacing", t2 - t1, 40);
  endtask

  task automatic t_latch;
    int t1, t2, t3, t4;
    wait_turnoff(t1);
    repeat (31) @(negedge clk);
    duty_cmd = 8'd20;
    wait_turnoff(t2);
    check("R10 no mid-period update", t2 - t1, 40);
    wait_turnoff(t3);
    check("R10 next period duty", t3 - t2, 50);
    duty_cmd = 8'd10;
    wait_turnoff(t4);
    check("R10 restore duty", t4 - t3, 30);
  endtask

  task automatic t_hold;
    int n;
    hold_cmd = 8'd5;
    wait_phase(4);
    count_phase(4, n, 1'b1);
    check("R7 hold 5", n, 5);
    hold_cmd = 8'd0;
    wait_phase(4);
    count_phase(4, n, 1'b1);
    check("R7 hold 0", n, 1);
    hold_cmd = 8'd2;
  endtask

  task automatic t_timeout;
    int n;
    wait_phase(2);
    resp_en = 1'b0;
    tmo_cmd = 8'd6;
    wait_phase(3);
    count_phase(3, n, 1'b1);
    check("R11 timeout length", n, 6);
    check("R11 forced reon", int'(phase), 5);
    check("R11 fault", int'(fault), 1);
    resp_en = 1'b1;
    tmo_cmd = 8'd20;
    wait_phase(4);
    check("R11 fault sticky", int'(fault), 1);
  endtask

  task automatic t_full;
    int bad;
    wait_phase(2);
    duty_cmd = 8'd50;
    wait_phase(1);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (phase != 3'd1 || sw_on != 4'hF) bad++;
    end
    check("R12 full duty", bad, 0);
    duty_cmd = 8'd10;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 fault cleared", int'(fault), 0);
    check("R1 gates off again", int'(sw_on), 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errs++;
    nchk++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin : main
    t_reset();
    t_first_seq();
    t_alternate();
    t_latch();
    t_hold();
    t_timeout();
    t_full();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule